// File: doc/BRIEF.md
# SMBus Host Controller Register Front-End

This block is the software-facing part of an SMBus host. Software programs a command byte, a slave address with a direction bit and two data bytes through a byte-wide register port. It can also fill or drain a 32-byte block buffer through a single data port that advances on every access. Writing the control register with its start bit set decodes a three-bit protocol code. If the code is usable, the block raises one abstract transaction request toward a downstream bus engine and holds it until the engine answers.

The engine answers with an acknowledge or a not-acknowledge, plus any returned data. The block stores the result in its data registers and sets completion or error flags in a status register that software clears by writing ones. During a block transfer the engine reaches the buffer through a separate index/data port. Bit-level bus signalling is left to the engine.

Top module: `smbus_host_regs`

## Requirements
- R1: After reset every register, the block buffer and the buffer index are zero, req_valid is low, and every offset reads 0.
- R2: Writing the status register (offset 0) clears each status bit at or above bit 1 whose written bit is 1, leaves bit 0 (busy) unchanged, and resets the buffer index to 0.
- R3: Reading the control register (offset 2) returns only its bits 4:0, with bits 7:5 reading 0, and resets the buffer index to 0. Offsets 3, 4, 5 and 6 read back the command, address, data0 and data1 bytes. Offset 1 and every offset above 7 read 0.
- R4: A control write with bit 6 set, while idle and with device error (status bit 2) clear, raises req_valid on the next cycle. The request carries: req_proto from control bits 4:2, req_read from address bit 0, req_slave from address bits 7:1, req_cmd from the command byte, req_data as {data1,data0}, and req_count as data0. Status bit 0 reads 1 and the request stays stable until rsp_valid.
- R5: Protocol codes 4, 6 and 7 issue no request and set device error (status bit 2). The usable codes are 0 quick, 1 send/receive byte, 2 byte data, 3 word data and 5 block.
- R6: A start requested while device error is set issues no request and leaves device error set.
- R7: An acknowledged response (rsp_valid with rsp_nack low) clears busy and sets byte-done (bit 7) and interrupt (bit 1) one cycle later.
- R8: A not-acknowledged response clears busy, sets device error, sets neither byte-done nor interrupt, and leaves data0 and data1 unchanged.
- R9: On an acknowledged read, protocols 1 and 2 load rsp_data[7:0] into data0, protocol 3 loads data0 with the low byte and data1 with the high byte, and protocol 5 loads rsp_count into data0. Writes and quick commands leave the data registers unchanged.
- R10: Each read or write of the block data port (offset 7) accesses buffer[index] and then increments the index, which wraps from 31 to 0.
- R11: The engine port reads any buffer byte combinationally through eng_buf_idx, and a byte it writes with eng_buf_we is later visible through the block data port.
- R12: When a response coincides with a register write, the response takes effect last: status flags it sets survive a same-cycle status clear, and the data it returns overrides a same-cycle data0 write.
- R13: A start requested while busy issues no new request and leaves the outstanding request unchanged, while the control value is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register byte write strobe |
| bus_rd | input | 1 | Register byte read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| req_valid | output | 1 | Transaction request outstanding |
| req_proto | output | 3 | Protocol code of the request |
| req_read | output | 1 | 1 = read direction |
| req_slave | output | 7 | 7-bit slave address |
| req_cmd | output | 8 | Command byte (send-byte payload) |
| req_data | output | 16 | {data1,data0} for byte/word writes |
| req_count | output | 8 | Byte count for block writes |
| rsp_valid | input | 1 | Engine response strobe |
| rsp_nack | input | 1 | Response is a not-acknowledge |
| rsp_data | input | 16 | Returned byte/word |
| rsp_count | input | 8 | Returned block byte count |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_idx | input | IDX_W | Engine buffer index |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Engine buffer read data |

## Verification
An engine response can arrive in the same cycle as a software register write. The case that matters is a response landing while software writes ones to clear the status register, or while it writes data0. The bench drives rsp_valid and the conflicting bus write on the same clock edge. It then reads status back and expects busy cleared with byte-done and interrupt still set, and it expects data0 to hold the returned byte rather than the written one. A second overlap is a start request while a transaction is outstanding. The bench checks that case by watching req_proto stay fixed while the control readback changes.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

    typedef enum logic [2:0] {
        PR_QUICK     = 3'd0,
        PR_BYTE      = 3'd1,
        PR_BYTE_DATA = 3'd2,
        PR_WORD      = 3'd3,
        PR_RSVD4     = 3'd4,
        PR_BLOCK     = 3'd5,
        PR_RSVD6     = 3'd6,
        PR_RSVD7     = 3'd7
    } proto_e;

    localparam int ST_BUSY   = 0;
    localparam int ST_INTR   = 1;
    localparam int ST_DEVERR = 2;
    localparam int ST_DONE   = 7;

    localparam int OFS_STAT  = 0;
    localparam int OFS_CTL   = 2;
    localparam int OFS_CMD   = 3;
    localparam int OFS_SADDR = 4;
    localparam int OFS_D0    = 5;
    localparam int OFS_D1    = 6;
    localparam int OFS_BLK   = 7;

    localparam int CTL_START = 6;

endpackage

// File: rtl/smbus_proto_decode.sv
module smbus_proto_decode
    import smbus_host_pkg::*;
(
    input  logic [2:0] code,
    output logic       supported,
    output logic       ld_low,
    output logic       ld_high,
    output logic       ld_count
);
    always_comb begin
        supported = 1'b0;
        ld_low    = 1'b0;
        ld_high   = 1'b0;
        ld_count  = 1'b0;
        case (proto_e'(code))
            PR_QUICK:     supported = 1'b1;
            PR_BYTE,
            PR_BYTE_DATA: begin
                supported = 1'b1;
                ld_low    = 1'b1;
            end
            PR_WORD: begin
                supported = 1'b1;
                ld_low    = 1'b1;
                ld_high   = 1'b1;
            end
            PR_BLOCK: begin
                supported = 1'b1;
                ld_count  = 1'b1;
            end
            default: supported = 1'b0;
        endcase
    end
endmodule

// File: rtl/smbus_blk_buf.sv
module smbus_blk_buf #(
    parameter  int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [7:0]       eng_wdata,
    output logic [7:0]       eng_rdata
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (host_we && host_idx == IDX_W'(i)) begin
                mem_d[i] = host_wdata;
            end
            // the engine writes last so its byte wins a same-cycle clash
            if (eng_we && eng_idx == IDX_W'(i)) begin
                mem_d[i] = eng_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign host_rdata = mem_q[host_idx];
    assign eng_rdata  = mem_q[eng_idx];
endmodule

// File: rtl/smbus_rd_mux.sv
module smbus_rd_mux
    import smbus_host_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        stat,
    input  logic [4:0]        ctl,
    input  logic [7:0]        cmd,
    input  logic [7:0]        saddr,
    input  logic [7:0]        d0,
    input  logic [7:0]        d1,
    input  logic [7:0]        blk,
    output logic [7:0]        rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_W'(OFS_STAT):  rdata = stat;
                ADDR_W'(OFS_CTL):   rdata = {3'b000, ctl};
                ADDR_W'(OFS_CMD):   rdata = cmd;
                ADDR_W'(OFS_SADDR): rdata = saddr;
                ADDR_W'(OFS_D0):    rdata = d0;
                ADDR_W'(OFS_D1):    rdata = d1;
                ADDR_W'(OFS_BLK):   rdata = blk;
                default:            rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbus_host_pkg::*;
#(
    parameter  int ADDR_W    = 6,
    parameter  int BUF_DEPTH = 32,
    localparam int IDX_W     = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              req_valid,
    output logic [2:0]        req_proto,
    output logic              req_read,
    output logic [6:0]        req_slave,
    output logic [7:0]        req_cmd,
    output logic [15:0]       req_data,
    output logic [7:0]        req_count,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic [15:0]       rsp_data,
    input  logic [7:0]        rsp_count,
    input  logic              eng_buf_we,
    input  logic [IDX_W-1:0]  eng_buf_idx,
    input  logic [7:0]        eng_buf_wdata,
    output logic [7:0]        eng_buf_rdata
);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_SADDR = ADDR_W'(OFS_SADDR);
    localparam logic [ADDR_W-1:0] A_D0    = ADDR_W'(OFS_D0);
    localparam logic [ADDR_W-1:0] A_D1    = ADDR_W'(OFS_D1);
    localparam logic [ADDR_W-1:0] A_BLK   = ADDR_W'(OFS_BLK);
    localparam logic [7:0]        BUSY_M  = 8'(1 << ST_BUSY);
    localparam logic [IDX_W-1:0]  IDX_TOP = IDX_W'(BUF_DEPTH - 1);

    typedef struct packed {
        logic [7:0]       stat;
        logic [4:0]       ctl;
        logic [7:0]       cmd;
        logic [7:0]       saddr;
        logic [7:0]       d0;
        logic [7:0]       d1;
        logic [IDX_W-1:0] idx;
        logic [2:0]       rproto;
        logic             rread;
        logic [6:0]       rslave;
        logic [7:0]       rcmd;
        logic [15:0]      rdata;
        logic [7:0]       rcnt;
    } state_t;

    state_t           q, n;
    logic [7:0]       clr, set;
    logic             busy;
    logic             host_we;
    logic [7:0]       blk_rdata;
    logic [IDX_W-1:0] idx_inc;
    logic [2:0]       dec_code;
    logic             code_ok, ld_low, ld_high, ld_count;
    logic [7:0]       stat_view;

    assign busy     = q.stat[ST_BUSY];
    assign idx_inc  = (q.idx == IDX_TOP) ? '0 : q.idx + 1'b1;
    // a start is only taken while idle and a response only arrives while
    // busy, so one decoder serves both
    assign dec_code = busy ? q.rproto : bus_wdata[4:2];

    smbus_proto_decode u_dec (
        .code      (dec_code),
        .supported (code_ok),
        .ld_low    (ld_low),
        .ld_high   (ld_high),
        .ld_count  (ld_count)
    );

    always_comb begin
        n       = q;
        clr     = '0;
        set     = '0;
        host_we = 1'b0;
        if (bus_wr) begin
            case (bus_addr)
                A_STAT: begin
                    clr   = bus_wdata & ~BUSY_M;
                    n.idx = '0;
                end
                A_CTL: begin
                    n.ctl = bus_wdata[4:0];
                    if (bus_wdata[CTL_START] && !busy && !q.stat[ST_DEVERR]) begin
                        if (!code_ok) begin
                            set[ST_DEVERR] = 1'b1;
                        end else begin
                            set[ST_BUSY] = 1'b1;
                            n.rproto     = bus_wdata[4:2];
                            n.rread      = q.saddr[0];
                            n.rslave     = q.saddr[7:1];
                            n.rcmd       = q.cmd;
                            n.rdata      = {q.d1, q.d0};
                            n.rcnt       = q.d0;
                        end
                    end
                end
                A_CMD:   n.cmd   = bus_wdata;
                A_SADDR: n.saddr = bus_wdata;
                A_D0:    n.d0    = bus_wdata;
                A_D1:    n.d1    = bus_wdata;
                A_BLK: begin
                    host_we = 1'b1;
                    n.idx   = idx_inc;
                end
                default: ;
            endcase
        end else if (bus_rd) begin
            if (bus_addr == A_CTL) begin
                n.idx = '0;
            end else if (bus_addr == A_BLK) begin
                n.idx = idx_inc;
            end
        end
        // response handling comes after the bus write so it takes precedence
        if (busy && rsp_valid) begin
            clr = clr | BUSY_M;
            if (rsp_nack) begin
                set[ST_DEVERR] = 1'b1;
            end else begin
                set[ST_DONE] = 1'b1;
                set[ST_INTR] = 1'b1;
                if (q.rread) begin
                    if (ld_low)   n.d0 = rsp_data[7:0];
                    if (ld_high)  n.d1 = rsp_data[15:8];
                    if (ld_count) n.d0 = rsp_count;
                end
            end
        end
        n.stat = (q.stat & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    smbus_blk_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_idx   (q.idx),
        .host_wdata (bus_wdata),
        .host_rdata (blk_rdata),
        .eng_we     (eng_buf_we),
        .eng_idx    (eng_buf_idx),
        .eng_wdata  (eng_buf_wdata),
        .eng_rdata  (eng_buf_rdata)
    );

    smbus_rd_mux #(.ADDR_W(ADDR_W)) u_mux (
        .rd_en (bus_rd),
        .addr  (bus_addr),
        .stat  (q.stat),
        .ctl   (q.ctl),
        .cmd   (q.cmd),
        .saddr (q.saddr),
        .d0    (q.d0),
        .d1    (q.d1),
        .blk   (blk_rdata),
        .rdata (bus_rdata)
    );

    assign stat_view = q.stat;
    assign req_valid = busy;
    assign req_proto = q.rproto;
    assign req_read  = q.rread;
    assign req_slave = q.rslave;
    assign req_cmd   = q.rcmd;
    assign req_data  = q.rdata;
    assign req_count = q.rcnt;
endmodule

// File: rtl/smbus_host_regs_chk.sv
module smbus_host_regs_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              req_valid,
    input logic [2:0]        req_proto,
    input logic              rsp_valid,
    input logic              rsp_nack,
    input logic [7:0]        stat
);
    logic ctl_start, bad_code;
    assign ctl_start = bus_wr && bus_addr == ADDR_W'(2) && bus_wdata[6];
    assign bad_code  = bus_wdata[4:2] == 3'd4 || bus_wdata[4:2] == 3'd6 || bus_wdata[4:2] == 3'd7;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !rsp_valid |=> req_valid); // R4
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) |-> $stable(req_proto)); // R13
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && (bus_addr == ADDR_W'(1) || bus_addr > ADDR_W'(7)) |-> bus_rdata == 8'h00); // R3
    AST_CTL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == ADDR_W'(2) |-> bus_rdata[7:5] == 3'b000); // R3
    AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(0) && !rsp_valid |=> (stat & $past(bus_wdata) & 8'hFE) == 8'h00); // R2
    AST_UNSUP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_start && !req_valid && bad_code |=> !req_valid && stat[2]); // R5
    AST_DEVERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_start && !req_valid && stat[2] |=> !req_valid && stat[2]); // R6
    AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_valid && !rsp_nack |=> !req_valid && stat[7] && stat[1]); // R7
    AST_NACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && rsp_valid && rsp_nack |=> !req_valid && stat[2]); // R8
endmodule

bind smbus_host_regs smbus_host_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_valid (req_valid),
    .req_proto (req_proto),
    .rsp_valid (rsp_valid),
    .rsp_nack  (rsp_nack),
    .stat      (stat_view)
);

// File: tb/test_smbus_host_regs.sv
`timescale 1ns/100ps
module test_smbus_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        req_valid, req_read;
    logic [2:0]  req_proto;
    logic [6:0]  req_slave;
    logic [7:0]  req_cmd, req_count;
    logic [15:0] req_data;
    logic        rsp_valid = 1'b0, rsp_nack = 1'b0;
    logic [15:0] rsp_data = '0;
    logic [7:0]  rsp_count = '0;
    logic        eng_buf_we = 1'b0;
    logic [4:0]  eng_buf_idx = '0;
    logic [7:0]  eng_buf_wdata = '0;
    logic [7:0]  eng_buf_rdata;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    smbus_host_regs i_smbus_host_regs (.*);

    // requirement-level model
    logic [7:0]  m_stat = 0, m_ctl = 0, m_cmd = 0, m_saddr = 0, m_d0 = 0, m_d1 = 0;
    logic [7:0]  m_buf [32];
    logic [4:0]  m_idx = 0;
    logic [2:0]  e_proto = 0;
    logic        e_rd = 0;
    logic [6:0]  e_slave = 0;
    logic [7:0]  e_cmd = 0, e_cnt = 0;
    logic [15:0] e_data = 0;

    initial for (int i = 0; i < 32; i++) m_buf[i] = 8'h00;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit usable(input logic [2:0] p);
        return p == 3'd0 || p == 3'd1 || p == 3'd2 || p == 3'd3 || p == 3'd5;
    endfunction

    task automatic model_wr(input logic [5:0] a, input logic [7:0] d);
        case (a)
            6'd0: begin m_stat = m_stat & ~(d & 8'hFE); m_idx = 0; end
            6'd2: begin
                m_ctl = d;
                if (d[6] && !m_stat[0] && !m_stat[2]) begin
                    if (!usable(d[4:2])) m_stat[2] = 1'b1;
                    else begin
                        m_stat[0] = 1'b1;
                        e_proto = d[4:2]; e_rd = m_saddr[0]; e_slave = m_saddr[7:1];
                        e_cmd = m_cmd; e_data = {m_d1, m_d0}; e_cnt = m_d0;
                    end
                end
            end
            6'd3: m_cmd = d;
            6'd4: m_saddr = d;
            6'd5: m_d0 = d;
            6'd6: m_d1 = d;
            6'd7: begin m_buf[m_idx] = d; m_idx = m_idx + 1'b1; end
            default: ;
        endcase
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        model_wr(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        if (a == 6'd2) m_idx = 0;
        if (a == 6'd7) m_idx = m_idx + 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input string tag);
        logic [7:0] exp, v;
        case (a)
            6'd0: exp = m_stat;
            6'd2: exp = m_ctl & 8'h1F;
            6'd3: exp = m_cmd;
            6'd4: exp = m_saddr;
            6'd5: exp = m_d0;
            6'd6: exp = m_d1;
            6'd7: exp = m_buf[m_idx];
            default: exp = 8'h00;
        endcase
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic serve(input bit nack, input logic [15:0] data, input logic [7:0] cnt,
                         input bit col, input logic [5:0] ca, input logic [7:0] cd);
        chk("R4 req_valid", req_valid, 1);
        chk("R4 req_proto", req_proto, e_proto);
        chk("R4 req_read", req_read, e_rd);
        chk("R4 req_slave", req_slave, e_slave);
        chk("R4 req_cmd", req_cmd, e_cmd);
        chk("R4 req_data", req_data, e_data);
        chk("R4 req_count", req_count, e_cnt);
        if (e_proto == 3'd5 && !nack) begin
            if (e_rd) begin
                for (int i = 0; i < 32 && i < int'(cnt); i++) begin
                    logic [7:0] b;
                    b = 8'($urandom);
                    eng_buf_we = 1'b1; eng_buf_idx = 5'(i); eng_buf_wdata = b;
                    m_buf[i] = b;
                    @(negedge clk);
                end
                eng_buf_we = 1'b0;
            end else begin
                for (int i = 0; i < 32 && i < int'(e_cnt); i++) begin
                    eng_buf_idx = 5'(i);
                    #1 chk("R11 engine read", eng_buf_rdata, m_buf[i]);
                    @(negedge clk);
                end
            end
        end
        rsp_valid = 1'b1; rsp_nack = nack; rsp_data = data; rsp_count = cnt;
        if (col) begin
            bus_wr = 1'b1; bus_addr = ca; bus_wdata = cd;
            model_wr(ca, cd);
        end
        m_stat[0] = 1'b0;
        if (nack) m_stat[2] = 1'b1;
        else begin
            m_stat = m_stat | 8'h82;
            if (e_rd) begin
                if (e_proto == 3'd1 || e_proto == 3'd2) m_d0 = data[7:0];
                if (e_proto == 3'd3) begin m_d0 = data[7:0]; m_d1 = data[15:8]; end
                if (e_proto == 3'd5) m_d0 = cnt;
            end
        end
        @(negedge clk);
        rsp_valid = 1'b0; bus_wr = 1'b0;
        chk("R7 busy cleared", req_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 req_valid", req_valid, 0);
        for (int a = 0; a < 8; a++) rd_chk(6'(a), "R1");
        rd(6'h20, v); chk("R3 unmapped", v, 8'h00);
        rd(6'h01, v); chk("R3 unmapped", v, 8'h00);

        // R5 / R6 / R2
        wr(2, 8'h50);
        chk("R5 no request", req_valid, 0);
        rd(0, v); chk("R5 deverr", v, 8'h04);
        wr(2, 8'h44);
        chk("R6 no request", req_valid, 0);
        rd(0, v); chk("R6 deverr held", v, 8'h04);
        wr(0, 8'h04);
        rd(0, v); chk("R2 cleared", v, 8'h00);

        // R10: wrap of the block index
        wr(0, 8'hFF);
        for (int i = 0; i < 33; i++) wr(7, 8'(8'h30 + i));
        rd_chk(2, "R3");
        rd(7, v); chk("R10 wrap overwrite", v, 8'h50);
        rd_chk(7, "R10");
        wr(0, 8'h00);
        rd(7, v); chk("R2 index reset", v, 8'h50);

        // R13: start while busy
        wr(0, 8'hFF); wr(3, 8'hA5); wr(4, 8'h2C);
        wr(2, 8'h44);
        wr(2, 8'h54);
        chk("R13 proto kept", req_proto, 3'd1);
        rd(2, v); chk("R13 ctl stored", v, 8'h14);
        serve(0, 16'h0000, 8'h00, 0, 0, 0);
        rd(0, v); chk("R7 done+intr", v, 8'h82);

        // R8: nack leaves data
        wr(0, 8'hFF); wr(4, 8'h31); wr(5, 8'h77);
        wr(2, 8'h48);
        serve(1, 16'h1234, 8'h00, 0, 0, 0);
        rd(0, v); chk("R8 nack status", v, 8'h04);
        rd(5, v); chk("R8 data kept", v, 8'h77);

        // R12: response vs status clear
        wr(0, 8'hFF); wr(4, 8'h40);
        wr(2, 8'h48);
        serve(0, 16'h0000, 8'h00, 1, 6'd0, 8'hFF);
        rd(0, v); chk("R12 set survives clear", v, 8'h82);

        // R12: response vs data0 write
        wr(0, 8'hFF); wr(4, 8'h21);
        wr(2, 8'h4C);
        serve(0, 16'hBEEF, 8'h00, 1, 6'd5, 8'h11);
        rd(5, v); chk("R12 data0 from response", v, 8'hEF);
        rd(6, v); chk("R9 word high", v, 8'hBE);

        // R9 / R11: block read then drain through the port
        wr(0, 8'hFF); wr(4, 8'h31);
        wr(2, 8'h54);
        serve(0, 16'h0000, 8'd5, 0, 0, 0);
        rd(5, v); chk("R9 block count", v, 8'd5);
        rd_chk(2, "R3");
        for (int i = 0; i < 5; i++) rd_chk(7, "R11 port view");

        // R11: block write exposes buffer to engine
        wr(0, 8'hFF); wr(7, 8'h9A); wr(7, 8'h9B); wr(7, 8'h9C);
        wr(5, 8'd3); wr(4, 8'h30);
        wr(2, 8'h54);
        serve(0, 16'h0000, 8'h00, 0, 0, 0);

        // random mix
        for (int it = 0; it < 80; it++) begin
            logic [2:0] p;
            wr(0, 8'hFF);
            wr(3, 8'($urandom)); wr(4, 8'($urandom));
            wr(5, 8'($urandom % 40)); wr(6, 8'($urandom));
            if ($urandom % 3 == 0) for (int k = 0; k < 4; k++) wr(7, 8'($urandom));
            p = 3'($urandom);
            wr(2, {1'($urandom), 1'b1, 1'($urandom), p, 2'($urandom)});
            if (m_stat[0]) serve(($urandom % 5) == 0, 16'($urandom), 8'($urandom % 33), 0, 0, 0);
            else chk("R5 no request", req_valid, 0);
            rd_chk(0, "R7");
            rd_chk(2, "R3");
            rd_chk(3, "R3");
            rd_chk(4, "R3");
            rd_chk(5, "R9");
            rd_chk(6, "R9");
            rd_chk(7, "R10");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule